// File: doc/BRIEF.md
# Configuration Image Header Detector

The detector watches a byte stream, one byte per cycle in which `in_valid` is high, and finds the start of a configuration image. An image opens with a 13-word (52-byte) header. The header holds all-ones filler words plus three sync words at word positions 8, 9 and 12. The block keeps the last 52 bytes in a sliding window, so every byte offset becomes a candidate start. It does not matter whether a header starts on a 4-byte boundary or whether an earlier candidate failed part way through.

Each header word is built from four consecutive bytes, most significant byte first. Sync words may instead arrive with the byte order reversed inside each word. The all-ones filler reads the same in either order, so it says nothing about byte order. The first sync word that only matches when its bytes are reversed puts the check into swapped mode. From then on a word is accepted in either order.

When a header is found, the block reports:
- a one-cycle pulse;
- the byte offset of the header;
- whether swapped order was seen;
- whether the header sat away from offset zero.

It then packs the bytes that follow the header into 32-bit words in the swapped layout. A stream-end strobe closes the current image. If no header was found by then, the strobe produces a not-found pulse. Either way, it restarts the search at offset zero.

Top module: `cfghdr_detect`

## Requirements
- R1: While reset is applied, and afterwards until a first event, `found`, `not_found` and `word_valid` are low, and `hdr_offset`, `hdr_swapped` and `hdr_unaligned` are zero.
- R2: A header sent in natural order (for each word: bits 31:24 first, bits 7:0 last) is recognised. The words are 0xFFFFFFFF at positions 0–7, 10 and 11, 0x000000BB at position 8, 0x11220044 at position 9 and 0xAA995566 at position 12. `found` is high in the cycle that follows the clock edge after the edge that accepted the 52nd header byte, with `hdr_swapped` = 0.
- R3: A header may start at any byte offset. `hdr_offset` counts bytes accepted since the last reset or stream end, and `hdr_unaligned` is 1 exactly when that offset is non-zero.
- R4: A candidate is examined only where its first four bytes are all 0xFF. A candidate that fails does not hide a later, overlapping candidate.
- R5: A header whose every word arrives byte-reversed (bits 7:0 first) is recognised with `hdr_swapped` = 1.
- R6: Swapped mode is taken at the first word whose reversed form equals a non-all-ones expected word. Every later word is then accepted in either order, and `hdr_swapped` = 1.
- R7: A header with a word that matches in neither order is not reported. A `stream_end` strobe during the search gives a one-cycle `not_found` pulse, and the next search counts offsets from zero.
- R8: After `found`, the bytes following the header are grouped in fours. `word_valid` pulses one cycle after the edge that accepts the fourth byte. When `hdr_swapped` = 0 the first byte of the group sits in bits 7:0; when it is 1 the first byte sits in bits 31:24.
- R9: A `stream_end` after `found` returns the block to searching without a `not_found` pulse. A partly filled word is dropped, and the next offset count starts at zero.
- R10: `found` lasts one cycle and is never high together with `not_found`. `hdr_offset`, `hdr_swapped` and `hdr_unaligned` keep their values until the next `found`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| stream_end | input | 1 | Strobe closing the current image; never high together with `in_valid` |
| found | output | 1 | One-cycle pulse: header recognised |
| hdr_offset | output | OFS_W | Byte offset of the recognised header |
| hdr_swapped | output | 1 | Header was seen in byte-reversed word order |
| hdr_unaligned | output | 1 | Header offset is not zero |
| not_found | output | 1 | One-cycle pulse: stream ended with no header |
| word_valid | output | 1 | `word_data` holds a packed body word |
| word_data | output | 32 | Body word in swapped layout |

## Verification
The embedded properties check these rules on every cycle:
- `found` is a single pulse and never coincides with `not_found`;
- the header fields stay frozen between detections;
- `hdr_unaligned` agrees with `hdr_offset`;
- a not-found pulse leaves the offset counter cleared;
- a hit always sits on an all-ones first word;
- the window holds still when no byte is taken;
- a body word only follows an accepted byte.

Other behaviours depend on the data and can only be shown by the bench's scenarios:
- the exact swap decision for natural, reversed and mixed headers;
- recovery of a header that overlaps a failed candidate;
- the orientation of the packed body words;
- rejection of a corrupted sync word;
- dropping a partial word at stream end.

// File: rtl/cfghdr_pkg.sv
// Shared constants, header pattern and helpers for the header detector.
// Assumes 32-bit header words made of four bytes.
package cfghdr_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int HDR_WORDS  = 13;
    localparam int HDR_BYTES  = HDR_WORDS * WORD_BYTES;

    localparam logic [WORD_W-1:0] FILL_WORD = 32'hFFFF_FFFF;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_PASS   = 1'b1
    } det_state_t;

    // Expected header word at a given position; sync words at 8, 9 and 12.
    function automatic logic [WORD_W-1:0] hdr_word(input int idx);
        case (idx)
            8:       return 32'h0000_00BB;
            9:       return 32'h1122_0044;
            12:      return 32'hAA99_5566;
            default: return FILL_WORD;
        endcase
    endfunction

    // Reverse the byte order inside one word.
    function automatic logic [WORD_W-1:0] rev_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/cfghdr_window.sv
// Sliding byte window: holds the last DEPTH accepted bytes.
// Byte 0 of win_flat (bits 7:0) is the oldest byte, i.e. the candidate start.
// Assumes the caller tracks how many bytes are valid.
module cfghdr_window #(
    parameter int DEPTH = 52
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift,
    input  logic [7:0]         byte_in,
    output logic [DEPTH*8-1:0] win_flat
);

    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (i == DEPTH - 1) begin : g_tail
            // Newest byte enters at the top of the window.
            always_ff @(posedge clk) begin
                if (!rst_n)     cells[i] <= '0;
                else if (shift) cells[i] <= byte_in;
            end
        end else begin : g_body
            // Every other cell takes its younger neighbour.
            always_ff @(posedge clk) begin
                if (!rst_n)     cells[i] <= '0;
                else if (shift) cells[i] <= cells[i+1];
            end
        end
        assign win_flat[i*8 +: 8] = cells[i];
    end

    // R4: the window never moves without an accepted byte.
    p_window_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(win_flat));

endmodule

// File: rtl/cfghdr_match.sv
// Header comparator: checks the window against the 13-word pattern.
// Each word may match as-is or byte-reversed, and a reversed match on a
// non-filler word latches swap mode for the words after it.
// Purely combinational; clk/rst_n serve only the embedded property.
module cfghdr_match #(
    parameter int WORDS = cfghdr_pkg::HDR_WORDS
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         full,
    input  logic [WORDS*cfghdr_pkg::WORD_BYTES*8-1:0]    win_flat,
    output logic                                         hit,
    output logic                                         swapped
);
    import cfghdr_pkg::*;

    logic [WORDS:0]   swap_chain;
    logic [WORDS-1:0] word_ok;

    assign swap_chain[0] = 1'b0;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam logic [WORD_W-1:0] PAT = hdr_word(i);
        logic [WORD_W-1:0] raw_w;
        logic [WORD_W-1:0] cur_w;
        logic [WORD_W-1:0] alt_w;
        logic              take_swap;

        // First stream byte is the most significant byte.
        assign raw_w = {win_flat[(4*i)*8 +: 8], win_flat[(4*i+1)*8 +: 8],
                        win_flat[(4*i+2)*8 +: 8], win_flat[(4*i+3)*8 +: 8]};
        // Word as seen under the swap mode reached so far.
        assign cur_w = swap_chain[i] ? rev_bytes(raw_w) : raw_w;
        assign alt_w = rev_bytes(cur_w);
        // Reversed form decides the order only if it is not the filler.
        assign take_swap       = (alt_w != FILL_WORD) && (alt_w == PAT);
        assign word_ok[i]      = take_swap || (cur_w == PAT);
        assign swap_chain[i+1] = swap_chain[i] | take_swap;
    end

    assign hit     = full && (&word_ok);
    assign swapped = swap_chain[WORDS];

    // R4: a hit always starts on an all-ones first word.
    p_first_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (win_flat[WORD_W-1:0] == FILL_WORD));

endmodule

// File: rtl/cfghdr_packer.sv
// Body packer: groups accepted bytes into words and emits each one in the
// swapped layout. With mode set, the first byte goes to the top byte lane;
// with mode clear, it goes to the bottom lane.
// Assumes clear and take are not both high.
module cfghdr_packer #(
    parameter int WB = cfghdr_pkg::WORD_BYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            take,
    input  logic [7:0]      byte_in,
    input  logic            mode,
    output logic            word_valid,
    output logic [WB*8-1:0] word_data
);

    localparam int IW = (WB > 1) ? $clog2(WB) : 1;
    localparam logic [IW-1:0] LAST = IW'(WB - 1);

    logic [7:0]      held [WB-1];
    logic [IW-1:0]   fill;
    logic [WB*8-1:0] msb_first;
    logic [WB*8-1:0] lsb_first;

    // Assemble the word that the current byte would complete.
    always_comb begin
        for (int k = 0; k < WB - 1; k++) begin
            msb_first[(WB-1-k)*8 +: 8] = held[k];
            lsb_first[k*8 +: 8]        = held[k];
        end
        msb_first[7:0]              = byte_in;
        lsb_first[(WB-1)*8 +: 8]    = byte_in;
    end

    // Collect bytes, emit a word on the last lane, drop partial words on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill       <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
            for (int k = 0; k < WB - 1; k++) held[k] <= '0;
        end else begin
            word_valid <= 1'b0;
            if (clear) begin
                fill <= '0;
            end else if (take) begin
                if (fill == LAST) begin
                    word_valid <= 1'b1;
                    word_data  <= mode ? msb_first : lsb_first;
                    fill       <= '0;
                end else begin
                    held[fill] <= byte_in;
                    fill       <= fill + 1'b1;
                end
            end
        end
    end

    // R8: a word appears only after a byte was accepted.
    p_word_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(take));

endmodule

// File: rtl/cfghdr_detect.sv
// Configuration image header detector (top).
// Searches a byte stream for the 52-byte header at any byte offset, reports
// offset, byte order and alignment, then packs the body into swapped-layout
// words until stream_end. Assumes stream_end and in_valid are never high together.
module cfghdr_detect #(
    parameter int OFS_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [7:0]                      in_byte,
    input  logic                            stream_end,
    output logic                            found,
    output logic [OFS_W-1:0]                hdr_offset,
    output logic                            hdr_swapped,
    output logic                            hdr_unaligned,
    output logic                            not_found,
    output logic                            word_valid,
    output logic [cfghdr_pkg::WORD_W-1:0]   word_data
);
    import cfghdr_pkg::*;

    localparam logic [OFS_W-1:0] HDR_LEN = OFS_W'(HDR_BYTES);
    localparam logic [OFS_W-1:0] CNT_MAX = '1;

    det_state_t           state;
    logic [OFS_W-1:0]     byte_cnt;
    logic [HDR_BYTES*8-1:0] win_flat;
    logic                 win_full;
    logic                 m_hit;
    logic                 m_swapped;
    logic                 hit_now;
    logic                 win_shift;
    logic                 pk_take;
    logic                 pk_clear;
    logic                 pk_mode;

    // Search-side control derived from the current state.
    always_comb begin
        win_full  = (byte_cnt >= HDR_LEN);
        hit_now   = (state == ST_SEARCH) && m_hit;
        win_shift = (state == ST_SEARCH) && in_valid && !stream_end && !hit_now;
        pk_take   = in_valid && !stream_end && ((state == ST_PASS) || hit_now);
        pk_clear  = stream_end || ((state == ST_SEARCH) && !hit_now);
        pk_mode   = (state == ST_SEARCH) ? m_swapped : hdr_swapped;
    end

    cfghdr_window #(.DEPTH(HDR_BYTES)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (win_shift),
        .byte_in  (in_byte),
        .win_flat (win_flat)
    );

    cfghdr_match #(.WORDS(HDR_WORDS)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .full     (win_full),
        .win_flat (win_flat),
        .hit      (m_hit),
        .swapped  (m_swapped)
    );

    cfghdr_packer #(.WB(WORD_BYTES)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pk_clear),
        .take       (pk_take),
        .byte_in    (in_byte),
        .mode       (pk_mode),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    // State, byte counter and header report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_SEARCH;
            byte_cnt      <= '0;
            found         <= 1'b0;
            not_found     <= 1'b0;
            hdr_offset    <= '0;
            hdr_swapped   <= 1'b0;
            hdr_unaligned <= 1'b0;
        end else begin
            found     <= 1'b0;
            not_found <= 1'b0;
            case (state)
                ST_SEARCH: begin
                    if (hit_now) begin
                        found         <= 1'b1;
                        hdr_offset    <= byte_cnt - HDR_LEN;
                        hdr_swapped   <= m_swapped;
                        hdr_unaligned <= (byte_cnt != HDR_LEN);
                        if (stream_end) byte_cnt <= '0;
                        else            state    <= ST_PASS;
                    end else if (stream_end) begin
                        not_found <= 1'b1;
                        byte_cnt  <= '0;
                    end else if (in_valid && byte_cnt != CNT_MAX) begin
                        byte_cnt <= byte_cnt + 1'b1;
                    end
                end
                ST_PASS: begin
                    if (stream_end) begin
                        state    <= ST_SEARCH;
                        byte_cnt <= '0;
                    end
                end
                default: state <= ST_SEARCH;
            endcase
        end
    end

    // R10: found is a single-cycle pulse.
    p_found_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> !found);

    // R10: found and not_found never coincide.
    p_found_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && not_found));

    // R10: report fields hold between detections.
    p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> ($stable(hdr_offset) && $stable(hdr_swapped) && $stable(hdr_unaligned)));

    // R3: the alignment flag agrees with the reported offset.
    p_unaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (hdr_unaligned == (hdr_offset != '0)));

    // R7: a not-found pulse leaves the search restarted at offset zero.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |-> (byte_cnt == '0) && (state == ST_SEARCH));

endmodule

// File: tb/cfghdr_detect_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected events, a monitor pops and compares.
module cfghdr_detect_bench;

    localparam int OFS_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = '0;
    logic             stream_end = 1'b0;
    logic             found;
    logic [OFS_W-1:0] hdr_offset;
    logic             hdr_swapped;
    logic             hdr_unaligned;
    logic             not_found;
    logic             word_valid;
    logic [31:0]      word_data;

    cfghdr_detect #(.OFS_W(OFS_W)) u_cfghdr_detect (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .stream_end(stream_end), .found(found), .hdr_offset(hdr_offset),
        .hdr_swapped(hdr_swapped), .hdr_unaligned(hdr_unaligned),
        .not_found(not_found), .word_valid(word_valid), .word_data(word_data)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          kind;   // 0 found, 1 not_found, 2 word
        int          ofs;
        int          swp;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   done = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input int ofs, input int swp,
                        input logic [31:0] data, input string tag);
        exp_t e;
        e.kind = kind; e.ofs = ofs; e.swp = swp; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare every output event against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (found || not_found || word_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10", "unexpected event", {29'd0, found, not_found, word_valid}, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.kind == 0) begin
                        check(e.tag, "found", {31'd0, found}, 32'd1);
                        check(e.tag, "offset", {16'd0, hdr_offset}, e.ofs);
                        check(e.tag, "swapped", {31'd0, hdr_swapped}, e.swp);
                        check("R3", "unaligned", {31'd0, hdr_unaligned}, (e.ofs != 0) ? 1 : 0);
                    end else if (e.kind == 1) begin
                        check(e.tag, "not_found", {31'd0, not_found}, 32'd1);
                        check("R10", "found with not_found", {31'd0, found}, 32'd0);
                    end else begin
                        check(e.tag, "word_valid", {31'd0, word_valid}, 32'd1);
                        check(e.tag, "word_data", word_data, e.data);
                    end
                end
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Word in natural order: bits 31:24 first.
    task automatic send_nat(input logic [31:0] w);
        send_byte(w[31:24]); send_byte(w[23:16]); send_byte(w[15:8]); send_byte(w[7:0]);
    endtask

    // Word byte-reversed: bits 7:0 first.
    task automatic send_swp(input logic [31:0] w);
        send_byte(w[7:0]); send_byte(w[15:8]); send_byte(w[23:16]); send_byte(w[31:24]);
    endtask

    function automatic logic [31:0] pat(input int i);
        case (i)
            8:       return 32'h0000_00BB;
            9:       return 32'h1122_0044;
            12:      return 32'hAA99_5566;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // mode 0 natural, 1 reversed, 2 natural up to word 8 then reversed.
    // bad_word >= 0 corrupts that word's low bit.
    task automatic send_header(input int mode, input int bad_word);
        for (int i = 0; i < 13; i++) begin
            logic [31:0] w;
            w = pat(i);
            if (i == bad_word) w = w ^ 32'h1;
            if (mode == 1 || (mode == 2 && i > 8)) send_swp(w);
            else send_nat(w);
        end
    endtask

    task automatic end_stream;
        stream_end = 1'b1;
        @(negedge clk);
        stream_end = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values while reset is applied.
        check("R1", "found", {31'd0, found}, 0);
        check("R1", "not_found", {31'd0, not_found}, 0);
        check("R1", "word_valid", {31'd0, word_valid}, 0);
        check("R1", "offset", {16'd0, hdr_offset}, 0);
        check("R1", "swapped", {31'd0, hdr_swapped}, 0);
        check("R1", "unaligned", {31'd0, hdr_unaligned}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: natural header at offset 0, with exact found timing; R8 body words.
        push(0, 0, 0, 0, "R2");
        send_header(0, -1);
        check("R2", "found before latency", {31'd0, found}, 0);
        @(negedge clk);
        check("R2", "found at latency", {31'd0, found}, 1);
        push(2, 0, 0, 32'hDDCC_BBAA, "R8");
        push(2, 0, 0, 32'h4433_2211, "R8");
        send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC); send_byte(8'hDD);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        // R9: a partial word is dropped and no not_found follows.
        send_byte(8'h55); send_byte(8'h66);
        end_stream();

        // R3/R5: reversed header after three junk bytes; offset counted from 0 (R9).
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
        push(0, 3, 1, 0, "R5");
        send_header(1, -1);
        push(2, 0, 0, 32'h0102_0304, "R8");
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
        repeat (3) @(negedge clk);
        check("R10", "offset held", {16'd0, hdr_offset}, 3);
        check("R10", "swapped held", {31'd0, hdr_swapped}, 1);
        end_stream();

        // R4: five 0xFF bytes start failing candidates; the real header is at 5.
        for (int k = 0; k < 5; k++) send_byte(8'hFF);
        push(0, 5, 0, 0, "R4");
        send_header(0, -1);
        end_stream();

        // R6: natural up to word 8, reversed afterwards.
        push(0, 0, 1, 0, "R6");
        send_header(2, -1);
        push(2, 0, 0, 32'h0A0B_0C0D, "R6");
        send_byte(8'h0A); send_byte(8'h0B); send_byte(8'h0C); send_byte(8'h0D);
        end_stream();

        // R7: corrupted sync word is rejected; stream end reports not_found.
        send_header(0, 9);
        push(1, 0, 0, 0, "R7");
        end_stream();

        // R7: search restarts at offset 0 after not_found.
        push(0, 0, 0, 0, "R7");
        send_header(0, -1);
        end_stream();

        // R7: empty stream ends as not_found.
        push(1, 0, 0, 0, "R7");
        end_stream();

        repeat (5) @(negedge clk);
        check("R10", "scoreboard left over", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule